// File: doc/BRIEF.md
# SDIO FIFO Window Length Decoder

This block sits behind the command decoder of an SDIO device function. It serves one multi-byte I/O command that targets the FIFO address window. The caller does not state a payload length. Instead it picks a start address that lies below a fixed window end, and the distance between the two is the number of meaningful bytes. The bus transfer itself can be longer: its length comes from the command's count field. In block mode that is the count times the block size. In byte mode it is the count alone, and a count of zero stands for 512 bytes.

The block moves bytes one by one between a byte stream on the bus side and a valid/ready port on each FIFO.

- **Slave-to-host (read):** the valid bytes are pulled from the transmit FIFO. Bytes past the valid length go out as zero.
- **Host-to-slave (write):** the valid bytes are pushed into the receive FIFO. Bytes past the valid length are accepted and thrown away.

Commands with an address outside the window, a wrong function number, a fixed-address op code, or a zero block-mode length are refused. A refused command raises an error flag and creates no traffic on either side.

Top module: `sdio_fwin_dec`

## Requirements
- R1: On an accepted command, `valid_len` becomes 0x1F800 minus `cmd_addr` at the clock edge that accepts the command. It stays unchanged until the next accepted command.
- R2: In byte mode (`cmd_block`=0), the bus transfer is exactly `cmd_count` bytes long, and a count of 0 gives 512 bytes.
- R3: In block mode (`cmd_block`=1), the bus transfer is exactly `cmd_count` × `blk_size` bytes long.
- R4: On a read (`cmd_write`=0), bus byte i for i < min(valid, bus length) is the i-th byte popped from the transmit FIFO, in order. While such a byte is pending and `fifo_rd_valid` is low, `bus_rd_valid` stays low (the bus stalls; no zero is inserted).
- R5: On a read, every bus byte at position ≥ valid length is 0x00 and is offered at once with `pad_active` high. No FIFO pop happens at these positions, so the total pop count is min(valid, bus length).
- R6: On a write (`cmd_write`=1), each bus byte at position < valid length is forwarded unchanged and in order to the receive FIFO. In that region `bus_wr_ready` follows `fifo_wr_ready`.
- R7: On a write, bus bytes at position ≥ valid length are accepted with `bus_wr_ready` high and `drop_active` high, and `fifo_wr_valid` stays low. The receive FIFO therefore gets min(valid, bus length) bytes.
- R8: A start in idle is refused if any of these holds: the address is below 0x090 or at or above 0x1F800; `cmd_func` is not 1; `cmd_incr` is 0; or the command is in block mode with a zero count or zero block size. On refusal, `err` goes high the next cycle, `busy` stays low, and no FIFO handshake occurs. The next accepted start clears `err`.
- R9: `done` pulses for one cycle in the cycle after the last bus byte, and `busy` falls in that same cycle. A `cmd_start` while `busy` is high is ignored.
- R10: After reset the block is idle. `busy`, `done`, `err`, `bus_rd_valid`, `bus_wr_ready`, `fifo_rd_ready` and `fifo_wr_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_addr | input | 17 | Start address of the access |
| cmd_func | input | 3 | Function number of the command |
| cmd_incr | input | 1 | Incrementing-address op code |
| cmd_write | input | 1 | 1 = host writes, 0 = host reads |
| cmd_block | input | 1 | 1 = block mode, 0 = byte mode |
| cmd_count | input | 9 | Block or byte count |
| blk_size | input | 12 | Block size in bytes |
| bus_rd_data | output | 8 | Byte toward the bus on reads |
| bus_rd_valid | output | 1 | Read byte available |
| bus_rd_ready | input | 1 | Bus takes the read byte |
| bus_wr_data | input | 8 | Byte from the bus on writes |
| bus_wr_valid | input | 1 | Write byte offered |
| bus_wr_ready | output | 1 | Block takes the write byte |
| fifo_rd_data | input | 8 | Transmit FIFO head byte |
| fifo_rd_valid | input | 1 | Transmit FIFO not empty |
| fifo_rd_ready | output | 1 | Pop transmit FIFO |
| fifo_wr_data | output | 8 | Byte to receive FIFO |
| fifo_wr_valid | output | 1 | Push receive FIFO |
| fifo_wr_ready | input | 1 | Receive FIFO has room |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was refused |
| valid_len | output | 17 | Valid length of current command |
| pad_active | output | 1 | Current read byte is zero fill |
| drop_active | output | 1 | Current write byte is discarded |

## Verification
The main sweep crosses valid lengths 1 to 6 with byte-mode bus lengths 1 to 8 in both directions. This covers bus lengths shorter than, equal to and longer than the valid length, which separates the pass-through path from the pad and drop paths.

Block-mode runs with a 3-byte block size and counts 1 to 3 check that the count is multiplied rather than passed through. A count of zero checks the 512-byte rule. A split 1024-plus-8-byte transfer checks the two-step window arithmetic.

The FIFO valid and bus ready patterns differ per run, so stalls fall on varying positions. A stall that inserted zeros instead of waiting would show up as misordered data. Refused commands cover each rejection reason at the window edges: 0x08F, 0x1F800, 0x1FFFF, a wrong function number, the fixed-address op code, and a zero block count. The lowest legal address 0x090 is also run and must be accepted.

// File: rtl/sdio_fwin_pkg.sv
package sdio_fwin_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } fwin_state_t;

  function automatic int fwin_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdio_fwin_len.sv
// Derives the valid length from the window end, the bus length from the
// count field, and whether the command must be refused.
module sdio_fwin_len #(
  parameter int               ADDR_W        = 17,
  parameter int               CNT_W         = 9,
  parameter int               BSZ_W         = 12,
  parameter int               BLEN_W        = 21,
  parameter logic [ADDR_W-1:0] END_ADDR     = 17'h1F800,
  parameter logic [ADDR_W-1:0] MIN_ADDR     = 17'h00090,
  parameter logic [2:0]       FIFO_FUNC     = 3'd1,
  parameter int               BYTE_ZERO_LEN = 512
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        func,
  input  logic              incr,
  input  logic              block,
  input  logic [CNT_W-1:0]  count,
  input  logic [BSZ_W-1:0]  bsz,
  output logic [ADDR_W-1:0] vlen,
  output logic [BLEN_W-1:0] blen,
  output logic              reject
);

  logic addr_bad;
  logic cmd_bad;
  logic blk_bad;

  always_comb begin
    vlen     = END_ADDR - addr;
    addr_bad = (addr < MIN_ADDR) || (addr >= END_ADDR);
    cmd_bad  = (func != FIFO_FUNC) || !incr;
    blk_bad  = block && ((count == '0) || (bsz == '0));
    reject   = addr_bad || cmd_bad || blk_bad;
  end

  always_comb begin
    if (block) begin
      blen = BLEN_W'(count) * BLEN_W'(bsz);
    end else if (count == '0) begin
      blen = BLEN_W'(BYTE_ZERO_LEN);
    end else begin
      blen = BLEN_W'(count);
    end
  end

endmodule

// File: rtl/sdio_fwin_cursor.sv
// Holds the lengths of the running command and the byte position.
module sdio_fwin_cursor import sdio_fwin_pkg::*; #(
  parameter int ADDR_W = 17,
  parameter int BLEN_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              beat,
  input  logic              active,
  input  logic [ADDR_W-1:0] vlen_in,
  input  logic [BLEN_W-1:0] blen_in,
  output logic [ADDR_W-1:0] vlen_q,
  output logic              in_data,
  output logic              last
);

  localparam int CMP_W = fwin_max(ADDR_W, BLEN_W);

  logic [BLEN_W-1:0] blen_q;
  logic [BLEN_W-1:0] pos_q;
  logic [BLEN_W-1:0] pos_d;
  logic              pos_en;

  always_comb begin
    pos_en  = load || beat;
    pos_d   = load ? '0 : (pos_q + 1'b1);
    in_data = CMP_W'(pos_q) < CMP_W'(vlen_q);
    last    = (pos_q == (blen_q - 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlen_q <= '0;
      blen_q <= '0;
    end else if (load) begin
      vlen_q <= vlen_in;
      blen_q <= blen_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  // R9
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pos_q < blen_q));

  // R1
  vlen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(vlen_q));

endmodule

// File: rtl/sdio_fwin_route.sv
// Steers bytes between the bus stream and the FIFO ports, with zero fill
// on reads and discard on writes past the valid length.
module sdio_fwin_route #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              write,
  input  logic              in_data,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              bus_rd_valid,
  input  logic              bus_rd_ready,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_wr_valid,
  output logic              bus_wr_ready,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_rd_valid,
  output logic              fifo_rd_ready,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  output logic              beat,
  output logic              pad,
  output logic              drop
);

  logic rd_on;
  logic wr_on;

  always_comb begin
    rd_on         = active && !write;
    wr_on         = active && write;
    bus_rd_data   = '0;
    bus_rd_valid  = 1'b0;
    fifo_rd_ready = 1'b0;
    bus_wr_ready  = 1'b0;
    fifo_wr_valid = 1'b0;
    fifo_wr_data  = bus_wr_data;
    if (rd_on) begin
      if (in_data) begin
        bus_rd_valid  = fifo_rd_valid;
        bus_rd_data   = fifo_rd_data;
        fifo_rd_ready = bus_rd_ready;
      end else begin
        bus_rd_valid  = 1'b1;
      end
    end
    if (wr_on) begin
      if (in_data) begin
        fifo_wr_valid = bus_wr_valid;
        bus_wr_ready  = fifo_wr_ready;
      end else begin
        bus_wr_ready  = 1'b1;
      end
    end
    beat = (bus_rd_valid && bus_rd_ready) || (bus_wr_valid && bus_wr_ready);
    pad  = rd_on && !in_data;
    drop = wr_on && !in_data;
  end

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad |-> (bus_rd_valid && (bus_rd_data == '0) && !fifo_rd_ready));

  // R7
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (bus_wr_ready && !fifo_wr_valid));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(bus_rd_valid || bus_wr_ready || fifo_rd_ready || fifo_wr_valid));

endmodule

// File: rtl/sdio_fwin_dec.sv
// Top: command acceptance, transfer sequencing and status.
module sdio_fwin_dec import sdio_fwin_pkg::*; #(
  parameter int                ADDR_W        = 17,
  parameter int                CNT_W         = 9,
  parameter int                BSZ_W         = 12,
  parameter int                DATA_W        = 8,
  parameter logic [ADDR_W-1:0] END_ADDR      = 17'h1F800,
  parameter logic [ADDR_W-1:0] MIN_ADDR      = 17'h00090,
  parameter logic [2:0]        FIFO_FUNC     = 3'd1,
  parameter int                BYTE_ZERO_LEN = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [2:0]        cmd_func,
  input  logic              cmd_incr,
  input  logic              cmd_write,
  input  logic              cmd_block,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [BSZ_W-1:0]  blk_size,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              bus_rd_valid,
  input  logic              bus_rd_ready,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_wr_valid,
  output logic              bus_wr_ready,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_rd_valid,
  output logic              fifo_rd_ready,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] valid_len,
  output logic              pad_active,
  output logic              drop_active
);

  localparam int BLEN_W = CNT_W + BSZ_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe[1];

  fwin_state_t       st_q, st_d;
  logic              dir_q, dir_d, dir_en;
  logic              err_q, err_d, err_en;
  logic              done_q, done_d;
  logic              accept, refuse;
  logic              beat, last, in_data, active;
  logic [ADDR_W-1:0] vlen_c;
  logic [BLEN_W-1:0] blen_c;
  logic              reject;

  sdio_fwin_len #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BSZ_W(BSZ_W), .BLEN_W(BLEN_W),
    .END_ADDR(END_ADDR), .MIN_ADDR(MIN_ADDR), .FIFO_FUNC(FIFO_FUNC),
    .BYTE_ZERO_LEN(BYTE_ZERO_LEN)
  ) u_len (
    .addr(cmd_addr), .func(cmd_func), .incr(cmd_incr), .block(cmd_block),
    .count(cmd_count), .bsz(blk_size),
    .vlen(vlen_c), .blen(blen_c), .reject(reject)
  );

  sdio_fwin_cursor #(.ADDR_W(ADDR_W), .BLEN_W(BLEN_W)) u_cursor (
    .clk(clk), .rst_n(rst_ni), .load(accept), .beat(beat), .active(active),
    .vlen_in(vlen_c), .blen_in(blen_c), .vlen_q(valid_len),
    .in_data(in_data), .last(last)
  );

  sdio_fwin_route #(.DATA_W(DATA_W)) u_route (
    .clk(clk), .rst_n(rst_ni), .active(active), .write(dir_q), .in_data(in_data),
    .bus_rd_data(bus_rd_data), .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready),
    .bus_wr_data(bus_wr_data), .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_valid(fifo_rd_valid), .fifo_rd_ready(fifo_rd_ready),
    .fifo_wr_data(fifo_wr_data), .fifo_wr_valid(fifo_wr_valid), .fifo_wr_ready(fifo_wr_ready),
    .beat(beat), .pad(pad_active), .drop(drop_active)
  );

  // next state
  always_comb begin
    active = (st_q == ST_XFER);
    accept = (st_q == ST_IDLE) && cmd_start && !reject;
    refuse = (st_q == ST_IDLE) && cmd_start && reject;
    st_d   = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_XFER;
      ST_XFER: if (beat && last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    dir_en = accept;
    dir_d  = cmd_write;
    err_en = accept || refuse;
    err_d  = refuse;
    done_d = active && beat && last;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign busy = active;
  assign done = done_q;
  assign err  = err_q;

  // R8
  refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && cmd_start && reject) |=> (err && !busy));

  // R9
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> ($past(st_q == ST_XFER) && !busy));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && cmd_start) |=> $stable(valid_len));

endmodule

// File: tb/tb_sdio_fwin_dec.sv
`timescale 1ns/1ps
module tb_sdio_fwin_dec;

  localparam logic [16:0] WEND = 17'h1F800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start, cmd_incr, cmd_write, cmd_block;
  logic [16:0] cmd_addr;
  logic [2:0]  cmd_func;
  logic [8:0]  cmd_count;
  logic [11:0] blk_size;
  logic [7:0]  bus_rd_data, bus_wr_data, fifo_rd_data, fifo_wr_data;
  logic        bus_rd_valid, bus_rd_ready, bus_wr_valid, bus_wr_ready;
  logic        fifo_rd_valid, fifo_rd_ready, fifo_wr_valid, fifo_wr_ready;
  logic        busy, done, err, pad_active, drop_active;
  logic [16:0] valid_len;

  int nvec = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  sdio_fwin_dec dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_func(cmd_func), .cmd_incr(cmd_incr), .cmd_write(cmd_write),
    .cmd_block(cmd_block), .cmd_count(cmd_count), .blk_size(blk_size),
    .bus_rd_data(bus_rd_data), .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready),
    .bus_wr_data(bus_wr_data), .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_valid(fifo_rd_valid), .fifo_rd_ready(fifo_rd_ready),
    .fifo_wr_data(fifo_wr_data), .fifo_wr_valid(fifo_wr_valid), .fifo_wr_ready(fifo_wr_ready),
    .busy(busy), .done(done), .err(err), .valid_len(valid_len),
    .pad_active(pad_active), .drop_active(drop_active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fsrc(input int i, input int s);
    return 8'((i * 13 + s * 7 + 1) & 255);
  endfunction

  function automatic logic [7:0] bsrc(input int i, input int s);
    return 8'((i * 29 + s * 3 + 5) & 255);
  endfunction

  task automatic idle_inputs();
    cmd_start = 0; cmd_addr = '0; cmd_func = 3'd1; cmd_incr = 1;
    cmd_write = 0; cmd_block = 0; cmd_count = '0; blk_size = 12'd4;
    bus_rd_ready = 0; bus_wr_valid = 0; bus_wr_data = '0;
    fifo_rd_valid = 0; fifo_rd_data = '0; fifo_wr_ready = 0;
  endtask

  // one accepted command, checked byte by byte
  task automatic run(input logic [16:0] addr, input bit wr, input bit blk,
                     input int cnt, input int bsz, input int exp_l,
                     input int seed, input bit poke);
    int v = int'(WEND - addr);
    int nv = (v < exp_l) ? v : exp_l;
    int bidx = 0;
    int fidx = 0;
    int cyc = 0;
    bit fin = 0;
    @(posedge clk); #1;
    cmd_start = 1; cmd_addr = addr; cmd_write = wr; cmd_block = blk;
    cmd_count = 9'(cnt); blk_size = 12'(bsz); cmd_func = 3'd1; cmd_incr = 1;
    @(posedge clk); #1;
    cmd_start = 0;
    chk("R1 valid_len", 32'(valid_len), 32'(v));
    chk("R9 busy after start", 32'(busy), 32'd1);
    while (!fin && cyc < 6000) begin
      cmd_start     = (poke && cyc == 1);
      if (poke && cyc == 1) cmd_addr = WEND - 17'd1;
      fifo_rd_valid = ((cyc + seed) % 3) != 0;
      fifo_rd_data  = fsrc(fidx, seed);
      bus_rd_ready  = ((cyc + 2 * seed) % 4) != 1;
      bus_wr_valid  = ((cyc + seed) % 5) != 2;
      bus_wr_data   = bsrc(bidx, seed);
      fifo_wr_ready = ((cyc + seed) % 3) != 1;
      @(negedge clk);
      if (!busy) begin
        fin = 1;
      end else if (!wr) begin
        if (bidx < nv && !fifo_rd_valid)
          chk("R4 stall while fifo empty", 32'(bus_rd_valid), 32'd0);
        if (fifo_rd_valid && fifo_rd_ready) fidx++;
        if (bus_rd_valid && bus_rd_ready) begin
          chk("R4/R5 read byte", 32'(bus_rd_data),
              (bidx < nv) ? 32'(fsrc(bidx, seed)) : 32'd0);
          chk("R5 pad flag", 32'(pad_active), 32'(bidx >= v));
          bidx++;
        end
      end else begin
        if (bidx < v)
          chk("R6 ready follows fifo", 32'(bus_wr_ready), 32'(fifo_wr_ready));
        if (fifo_wr_valid && fifo_wr_ready) begin
          chk("R6 forwarded byte", 32'(fifo_wr_data), 32'(bsrc(bidx, seed)));
          fidx++;
        end
        if (bus_wr_valid && bus_wr_ready) begin
          chk("R7 drop flag", 32'(drop_active), 32'(bidx >= v));
          bidx++;
        end
      end
      if (!fin) begin
        @(posedge clk); #1;
        cyc++;
      end
    end
    if (!fin) chk("watchdog transfer", 32'd0, 32'd1);
    chk(blk ? "R3 bus length" : "R2 bus length", 32'(bidx), 32'(exp_l));
    chk(wr ? "R7 fifo pushes" : "R5 fifo pops", 32'(fidx), 32'(nv));
    chk("R9 done pulse", 32'(done), 32'd1);
    chk("R1 valid_len held", 32'(valid_len), 32'(v));
    chk("R8 err clear", 32'(err), 32'd0);
    @(posedge clk); #1;
    bus_rd_ready = 0; bus_wr_valid = 0; fifo_rd_valid = 0; fifo_wr_ready = 0;
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic refuse(input logic [16:0] addr, input logic [2:0] fn,
                        input bit inc, input bit blk, input int cnt);
    @(posedge clk); #1;
    cmd_start = 1; cmd_addr = addr; cmd_func = fn; cmd_incr = inc;
    cmd_block = blk; cmd_count = 9'(cnt); blk_size = 12'd4; cmd_write = 0;
    bus_rd_ready = 1; bus_wr_valid = 1; fifo_rd_valid = 1; fifo_wr_ready = 1;
    @(posedge clk); #1;
    cmd_start = 0;
    chk("R8 err set", 32'(err), 32'd1);
    chk("R8 no busy", 32'(busy), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 no fifo traffic", 32'({fifo_rd_ready, fifo_wr_valid}), 32'd0);
    end
    idle_inputs();
  endtask

  initial begin
    int seed = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset busy", 32'(busy), 32'd0);
    chk("R10 reset done/err", 32'({done, err}), 32'd0);
    chk("R10 reset handshakes",
        32'({bus_rd_valid, bus_wr_ready, fifo_rd_ready, fifo_wr_valid}), 32'd0);
    rst_n = 1;
    repeat (4) @(posedge clk);

    for (int v = 1; v <= 6; v++)
      for (int l = 1; l <= 8; l++)
        for (int w = 0; w < 2; w++) begin
          run(WEND - 17'(v), w[0], 1'b0, l, 4, l, seed, 1'b0);
          seed++;
        end

    for (int c = 1; c <= 3; c++)
      for (int w = 0; w < 2; w++) begin
        run(WEND - 17'd2,  w[0], 1'b1, c, 3, 3 * c, seed, 1'b0); seed++;
        run(WEND - 17'd5,  w[0], 1'b1, c, 3, 3 * c, seed, 1'b0); seed++;
        run(WEND - 17'd10, w[0], 1'b1, c, 3, 3 * c, seed, 1'b0); seed++;
      end

    // R2 count zero in byte mode
    run(WEND - 17'd3, 1'b0, 1'b0, 0, 4, 512, seed, 1'b0); seed++;
    run(WEND - 17'd3, 1'b1, 1'b0, 0, 4, 512, seed, 1'b0); seed++;

    // R3 split transfer: two 512-byte blocks, then 8 bytes with 7 valid
    run(WEND - 17'd1031, 1'b0, 1'b1, 2, 512, 1024, seed, 1'b0); seed++;
    run(WEND - 17'd7,    1'b0, 1'b0, 8, 4,   8,    seed, 1'b0); seed++;
    run(WEND - 17'd1031, 1'b1, 1'b1, 2, 512, 1024, seed, 1'b0); seed++;

    // R1 lowest legal address
    run(17'h00090, 1'b0, 1'b0, 4, 4, 4, seed, 1'b0); seed++;

    // R9 start while busy is ignored
    run(WEND - 17'd4, 1'b0, 1'b0, 6, 4, 6, seed, 1'b1); seed++;

    // R8 refusals
    refuse(17'h0008F, 3'd1, 1'b1, 1'b0, 4);
    refuse(17'h1F800, 3'd1, 1'b1, 1'b0, 4);
    refuse(17'h1FFFF, 3'd1, 1'b1, 1'b0, 4);
    refuse(17'h1F700, 3'd2, 1'b1, 1'b0, 4);
    refuse(17'h1F700, 3'd1, 1'b0, 1'b0, 4);
    refuse(17'h1F700, 3'd1, 1'b1, 1'b1, 0);
    run(WEND - 17'd2, 1'b1, 1'b0, 3, 4, 3, seed, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule